// File: doc/BRIEF.md
# Two-Channel Hall Speed and Direction Decoder

This block turns the threshold-crossing flags of two magnetic sensing channels into a speed output and a direction output. Each channel has two one-bit flags. The "operate" flag means the field went above the operate threshold (South pole). The "release" flag means the field went below the release threshold (North pole). A per-channel hysteresis latch keeps the last pole seen. When neither flag is set, the latch holds its value.

A free-running counter produces a refresh tick every `REFRESH_CYCLES` clocks. On each tick the two latched poles are sampled and compared with the previous sample.
- A change of exactly one channel is decoded into a rotation sense. The direction output is updated one cycle after the tick.
- The speed output follows the first channel only. It is updated exactly `DIR_LEAD_CYCLES` cycles after the direction output, so a downstream counter always sees the new direction before the speed edge.
- A sample in which both channels changed at once cannot be decoded. It leaves direction alone and pulses an error flag.

The default parameters suit a 50 MHz clock:
- a 5 µs refresh period (250 cycles);
- a 1.2 µs direction lead (60 cycles).

With these values, field transitions at 40 kHz are resolved with more than two samples per transition.

Top module: `hsd_top`

## Requirements
- R1: Each channel latch becomes South (1) on a cycle with its operate flag set and its release flag clear. It becomes North (0) on a cycle with its release flag set and its operate flag clear. It holds its state when both flags are clear or both are set.
- R2: The latched poles are sampled once every `REFRESH_CYCLES` clocks. The direction output changes only in the cycle after a refresh sample, so a change appears within `REFRESH_CYCLES`+3 cycles of the flag pulse.
- R3: The speed output is driven low while channel 0 (the first channel) is South and high while it is North. A change of channel 1 alone never toggles speed.
- R4: With poles written as (ch0,ch1) and S=1, N=0, each single-channel step of the cycle (N,S)→(N,N)→(S,N)→(S,S)→(N,S) sets the direction output to 0.
- R5: Each single-channel step of the cycle (N,S)→(S,S)→(S,N)→(N,N)→(N,S) sets the direction output to 1. This also holds when it immediately follows a step of the R4 cycle (reversal).
- R6: When one sample changes both outputs, the speed output changes exactly `DIR_LEAD_CYCLES` cycles after the direction output.
- R7: After reset the speed output is 1, the direction output is 1 and the error output is 0. Both channels start North.
- R8: A sample in which both channels changed leaves the direction output unchanged. It raises the error output for exactly one cycle. Speed still follows channel 0.
- R9: A sample identical to the previous one toggles neither output and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_hit_i | input | 2 | Operate-threshold crossing flag per channel (bit 0 = first channel) |
| rel_hit_i | input | 2 | Release-threshold crossing flag per channel (bit 0 = first channel) |
| spd_o | output | 1 | Speed output: low while channel 0 is South |
| dir_o | output | 1 | Direction output: 0 for one rotation sense, 1 for the other |
| err_o | output | 1 | One-cycle pulse on a sample where both channels changed |

## Verification
The decoder is driven through both four-step rotation cycles in full. This separates the two senses and shows that a channel-1 step leaves speed alone while a channel-0 step moves it. A reversal in the middle of motion is also applied, proving that the sense is decided per step and not remembered from earlier steps. Redundant and contradictory flag pulses separate a real pole change from a held state. A simultaneous flip of both channels separates the illegal path, which raises the error flag and keeps direction, from a legal step. On every step where both outputs move, the spacing between the direction edge and the speed edge is measured.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
    // pole encoding shared by latches and sequencer
    typedef enum logic {
        POLE_N = 1'b0,
        POLE_S = 1'b1
    } pole_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/hsd_latch.sv
module hsd_latch
    import hsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_i,
    input  logic rel_i,
    output logic pole_o
);
    pole_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op_i && !rel_i)
            st_d = POLE_S;
        else if (rel_i && !op_i)
            st_d = POLE_N;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= POLE_N;
        else
            st_q <= st_d;
    end

    assign pole_o = st_q;

    // R1: a lone operate flag makes the channel South
    p_south_on_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i && !rel_i) |=> (pole_o == 1'b1));

    // R1: a lone release flag makes the channel North
    p_north_on_rel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i && !op_i) |=> (pole_o == 1'b0));

    // R1: equal flags hold the state
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == rel_i) |=> $stable(pole_o));
endmodule

// File: rtl/hsd_refresh.sv
module hsd_refresh #(
    parameter int PERIOD = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);

    // R2: ticks are isolated, never back to back
    p_tick_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/hsd_seq.sv
module hsd_seq
    import hsd_pkg::*;
#(
    parameter int LEAD = 60
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [NUM_CH-1:0]   pair_i,
    output logic                spd_o,
    output logic                dir_o,
    output logic                err_o
);
    localparam int CW = (LEAD > 1) ? $clog2(LEAD) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(LEAD - 1);

    typedef struct packed {
        logic [NUM_CH-1:0] prev;
        logic              dir;
        logic              spd;
        logic              err;
        logic              pend;
        logic [CW-1:0]     cnt;
        logic              tgt;
    } seq_t;

    seq_t s_d, s_q;
    logic [NUM_CH-1:0] chg;
    logic fwd;

    always_comb begin
        chg = pair_i ^ s_q.prev;
        // step of channel 1: forward when it lands equal to channel 0
        // step of channel 0: forward when it lands different from channel 1
        fwd = chg[1] ? ~(pair_i[0] ^ pair_i[1]) : (pair_i[0] ^ pair_i[1]);

        s_d     = s_q;
        s_d.err = 1'b0;

        if (s_q.pend) begin
            if (s_q.cnt == CNT_LAST) begin
                s_d.spd  = s_q.tgt;
                s_d.pend = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end

        if (tick_i) begin
            s_d.prev = pair_i;
            if (chg != '0) begin
                s_d.pend = 1'b1;
                s_d.cnt  = '0;
                s_d.tgt  = ~pair_i[0];
                if (chg == 2'b11)
                    s_d.err = 1'b1;
                else
                    s_d.dir = ~fwd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.prev <= {POLE_N, POLE_N};
            s_q.dir  <= 1'b1;
            s_q.spd  <= 1'b1;
            s_q.tgt  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign spd_o = s_q.spd;
    assign dir_o = s_q.dir;
    assign err_o = s_q.err;

    // R2: direction moves only right after a refresh sample
    p_dir_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_o) |-> $past(tick_i));

    // R6: speed moves only when a pending lead interval ends
    p_spd_after_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spd_o) |-> ($past(s_q.pend) && !s_q.pend));

    // R8: error is a single-cycle pulse
    p_err_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R8: an illegal sample keeps direction
    p_illegal_keeps_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(dir_o));
endmodule

// File: rtl/hsd_top.sv
module hsd_top
    import hsd_pkg::*;
#(
    parameter int REFRESH_CYCLES  = 250,
    parameter int DIR_LEAD_CYCLES = 60
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   op_hit_i,
    input  logic [NUM_CH-1:0]   rel_hit_i,
    output logic                spd_o,
    output logic                dir_o,
    output logic                err_o
);
    logic [NUM_CH-1:0] pole;
    logic              tick;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        hsd_latch u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .op_i   (op_hit_i[g]),
            .rel_i  (rel_hit_i[g]),
            .pole_o (pole[g])
        );
    end

    hsd_refresh #(.PERIOD(REFRESH_CYCLES)) u_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    hsd_seq #(.LEAD(DIR_LEAD_CYCLES)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .pair_i (pole),
        .spd_o  (spd_o),
        .dir_o  (dir_o),
        .err_o  (err_o)
    );

    // R3: speed never changes on a sample where channel 0 did not move
    p_spd_tracks_ch0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(spd_o)) |-> (spd_o == ~pole[0]));
endmodule

// File: tb/sim_hsd_top.sv
module sim_hsd_top;
    localparam int CLK_PERIOD = 10;
    localparam int RP = 16;
    localparam int LD = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] op_hit = '0;
    logic [1:0] rel_hit = '0;
    logic spd, dir, err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int dir_cyc = 0, spd_cyc = 0;
    int dir_tog = 0, spd_tog = 0;
    int err_cnt = 0, err_run = 0, err_maxw = 0;
    logic dir_prev = 1'b1, spd_prev = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsd_top #(.REFRESH_CYCLES(RP), .DIR_LEAD_CYCLES(LD)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_hit_i  (op_hit),
        .rel_hit_i (rel_hit),
        .spd_o     (spd),
        .dir_o     (dir),
        .err_o     (err)
    );

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (dir !== dir_prev) begin dir_tog++; dir_cyc = cyc; end
            if (spd !== spd_prev) begin spd_tog++; spd_cyc = cyc; end
            if (err) begin
                err_run++;
                if (err_run == 1) err_cnt++;
                if (err_run > err_maxw) err_maxw = err_run;
            end else begin
                err_run = 0;
            end
        end
        dir_prev = dir;
        spd_prev = spd;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one flag pulse, then wait past the next sample and the lead interval
    task automatic step(input string req, input logic [1:0] op, input logic [1:0] rel,
                        input logic exp_dir, input logic exp_spd,
                        input int exp_dt, input int exp_st, input int exp_err);
        int b_d, b_s, b_e, start;
        b_d = dir_tog; b_s = spd_tog; b_e = err_cnt;
        @(negedge clk);
        op_hit = op; rel_hit = rel; start = cyc;
        @(negedge clk);
        op_hit = '0; rel_hit = '0;
        repeat (2*RP + 4) @(negedge clk);
        chk(dir === exp_dir, req, "dir level", int'(dir), int'(exp_dir));
        chk(spd === exp_spd, req, "spd level", int'(spd), int'(exp_spd));
        chk(dir_tog - b_d == exp_dt, req, "dir toggles", dir_tog - b_d, exp_dt);
        chk(spd_tog - b_s == exp_st, req, "spd toggles", spd_tog - b_s, exp_st);
        chk(err_cnt - b_e == exp_err, req, "err pulses", err_cnt - b_e, exp_err);
        if (exp_dt == 1) begin
            // R2: direction edge lands within one refresh period of the pulse
            chk((dir_cyc - start >= 1) && (dir_cyc - start <= RP + 3), "R2",
                "dir latency", dir_cyc - start, RP);
        end
        if (exp_dt == 1 && exp_st == 1) begin
            // R6: speed lags direction by the lead count
            chk(spd_cyc - dir_cyc == LD, "R6", "dir-to-spd spacing",
                spd_cyc - dir_cyc, LD);
        end
    endtask

    task automatic t_reset;
        chk(spd === 1'b1, "R7", "reset spd", int'(spd), 1);
        chk(dir === 1'b1, "R7", "reset dir", int'(dir), 1);
        chk(err === 1'b0, "R7", "reset err", int'(err), 0);
    endtask

    // encoding (ch0,ch1), S=1: cycle 00 -> 10 -> 11 -> 01 -> 00 is R4
    task automatic t_forward;
        step("R4", 2'b01, 2'b00, 1'b0, 1'b0, 1, 1, 0); // ch0 S: speed low (R3)
        step("R3", 2'b10, 2'b00, 1'b0, 1'b0, 0, 0, 0); // ch1 S: no speed move
        step("R4", 2'b00, 2'b01, 1'b0, 1'b1, 0, 1, 0); // ch0 N: speed high
        step("R4", 2'b00, 2'b10, 1'b0, 1'b1, 0, 0, 0); // back to 00
    endtask

    // cycle 00 -> 01 -> 11 -> 10 -> 00 is R5
    task automatic t_reverse;
        step("R5", 2'b10, 2'b00, 1'b1, 1'b1, 1, 0, 0);
        step("R5", 2'b01, 2'b00, 1'b1, 1'b0, 0, 1, 0);
        step("R5", 2'b00, 2'b10, 1'b1, 1'b0, 0, 0, 0);
        step("R5", 2'b00, 2'b01, 1'b1, 1'b1, 0, 1, 0);
    endtask

    task automatic t_reversal;
        step("R4", 2'b01, 2'b00, 1'b0, 1'b0, 1, 1, 0); // 00 -> 10 forward
        step("R5", 2'b00, 2'b01, 1'b1, 1'b1, 1, 1, 0); // 10 -> 00 backward
    endtask

    task automatic t_hold;
        step("R9", 2'b00, 2'b11, 1'b1, 1'b1, 0, 0, 0); // already North
        step("R1", 2'b01, 2'b01, 1'b1, 1'b1, 0, 0, 0); // contradictory flags
        step("R1", 2'b00, 2'b00, 1'b1, 1'b1, 0, 0, 0); // no flags
    endtask

    task automatic t_illegal;
        step("R8", 2'b11, 2'b00, 1'b1, 1'b0, 0, 1, 1); // 00 -> 11
        step("R8", 2'b00, 2'b11, 1'b1, 1'b1, 0, 1, 1); // 11 -> 00
        chk(err_maxw == 1, "R8", "err pulse width", err_maxw, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_forward();
        t_reverse();
        t_reversal();
        t_hold();
        t_illegal();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired (all requirements): actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule